// File: doc/BRIEF.md
# Timer Input Noise Filter and Capture Trigger Select

This block sits between two timer input pins and the capture or counting logic behind them. Each pin first passes through a two-flop synchronizer. It then goes either through a majority-free stability filter or, when that pin's filter is switched off, straight to edge detection. The filter looks at the synchronized pin only on a sampling strobe. A new level is accepted only after three consecutive strobes have seen it. The strobe comes from one of four sources: the system clock divided by 32 or by 8, the undivided system clock, or a count-source tick supplied by the timer.

For each pin the block drives a registered level plus one-clock rising and falling pulses. It also produces a single capture request. The request is taken either from the pin 0 path, with a configurable edge, or from an internal event line. The event line is honoured only when the capture edge is set to rising. The strobe select and the trigger source are held in registers that accept a write only while the timer is running.

Top module: `tif_capture_front`

## Requirements
- R1: After reset the strobe select is 00 and the trigger source is 0. Each `lvl_o` bit equals its pin's level at reset. No rise, fall or capture pulse appears without a later pin change.
- R2: With a pin's filter enable at 0, a pin change reaches `lvl_o` and its edge pulse 3 clocks later, whatever the strobe select.
- R3: With the filter enabled, the filtered level changes only after 3 consecutive strobes have seen the new synchronized level. With the undivided clock as strobe, a 2-clock pulse is rejected and a 3-clock pulse passes with a latency of 6 clocks.
- R4: Strobe select encoding: 00 = clock/32, 01 = clock/8, 10 = every clock, 11 = `cnt_src_tick_i`. With strobe period P clocks, a filtered edge appears between 2P+4 and 3P+3 clocks after the pin change. A pulse that spans no more than 2 strobes is rejected.
- R5: `rise_o[i]` and `fall_o[i]` are one clock wide, never both high, follow `lvl_o[i]`, and each pin's outputs are independent of the other pin.
- R6: With trigger source 0, `cap_req_o` pulses one clock after the pin 0 edge chosen by `cap_edge_i` (00 rising, 01 falling, 10 both, 11 none).
- R7: With trigger source 1, `cap_req_o` pulses one clock after `evt_i` only when `cap_edge_i` is 00. Otherwise, and for pin 0 edges, it stays low.
- R8: `cfg_we_i` loads `fsel_i` and `cap_src_i` only while `start_i` is 1. A write while `start_i` is 0 leaves both settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Timer running; enables configuration writes |
| cfg_we_i | input | 1 | Configuration write strobe |
| fsel_i | input | 2 | Strobe select value to write |
| cap_src_i | input | 1 | Trigger source value to write (0 pin 0, 1 event) |
| flt_en_i | input | NPIN | Per-pin filter enable |
| cnt_src_tick_i | input | 1 | Timer count-source tick, one clock wide |
| cap_edge_i | input | 2 | Pin 0 capture edge: 00 rise, 01 fall, 10 both, 11 none |
| pin_i | input | NPIN | Asynchronous input pins |
| evt_i | input | 1 | Internal event line |
| lvl_o | output | NPIN | Conditioned pin levels |
| rise_o | output | NPIN | Rising-edge pulses |
| fall_o | output | NPIN | Falling-edge pulses |
| cap_req_o | output | 1 | Capture request pulse |

## Verification
A bypassed pin reaches its level and edge outputs after 3 clocks. A filtered pin reaches them after 6 clocks when the undivided clock is the strobe. The capture request follows one clock after the pin edge, or one clock after `evt_i`. These exact latencies are checked on the sampling half-cycle after the stated number of rising edges. The prescaler phase is free-running, so divided and tick-driven strobes are checked against the window from 2P+4 to 3P+3 clocks rather than a single cycle. Every stimulus is applied after a quiet interval longer than the slowest window, so one vector's pulses cannot leak into the next.

// File: rtl/tif_pkg.sv
package tif_pkg;
  typedef enum logic [1:0] {
    FSEL_DIV32  = 2'b00,
    FSEL_DIV8   = 2'b01,
    FSEL_SYS    = 2'b10,
    FSEL_CNTSRC = 2'b11
  } fsel_e;

  typedef enum logic [1:0] {
    CEDGE_RISE = 2'b00,
    CEDGE_FALL = 2'b01,
    CEDGE_BOTH = 2'b10,
    CEDGE_NONE = 2'b11
  } cedge_e;
endpackage

// File: rtl/tif_strobe_gen.sv
module tif_strobe_gen
  import tif_pkg::*;
#(
  parameter int DIV_FAST = 8,
  parameter int DIV_SLOW = 32
) (
  input  logic  clk,
  input  logic  rst,
  input  fsel_e fsel_i,
  input  logic  cnt_src_tick_i,
  output logic  stb_o
);
  logic [1:0] div_stb;

  // one free-running counter per divider; each yields a one-clock enable
  for (genvar g = 0; g < 2; g++) begin : g_div
    localparam int D  = (g == 0) ? DIV_FAST : DIV_SLOW;
    localparam int CW = (D > 1) ? $clog2(D) : 1;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst || cnt_q == CW'(D - 1)) cnt_q <= '0;
      else                            cnt_q <= cnt_q + 1'b1;
    end

    assign div_stb[g] = (cnt_q == CW'(D - 1));

    if (D > 1) begin : g_chk
      assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        div_stb[g] |=> !div_stb[g]);
    end
  end

  always_comb begin
    unique case (fsel_i)
      FSEL_DIV32:  stb_o = div_stb[1];
      FSEL_DIV8:   stb_o = div_stb[0];
      FSEL_SYS:    stb_o = 1'b1;
      FSEL_CNTSRC: stb_o = cnt_src_tick_i;
      default:     stb_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tif_pin_filter.sv
module tif_pin_filter #(
  parameter int STABLE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic en_i,
  input  logic stb_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;

  logic          s1_q, s2_q, flt_q;
  logic [CW-1:0] agree_q;
  logic          lvl_q, rise_q, fall_q;
  logic          lvl_now;

  assign lvl_now = en_i ? flt_q : s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q    <= pin_i;
      s2_q    <= pin_i;
      flt_q   <= pin_i;
      agree_q <= '0;
      lvl_q   <= pin_i;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (!en_i) begin
        flt_q   <= s2_q;
        agree_q <= '0;
      end else if (stb_i) begin
        if (s2_q == flt_q) begin
          agree_q <= '0;
        end else if (agree_q == CW'(STABLE - 1)) begin
          flt_q   <= s2_q;
          agree_q <= '0;
        end else begin
          agree_q <= agree_q + 1'b1;
        end
      end
      lvl_q  <= lvl_now;
      rise_q <= lvl_now & ~lvl_q;
      fall_q <= ~lvl_now & lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  assert_hold_off_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(en_i) && !$past(stb_i)) |-> $stable(flt_q));
  assert_accept_synced_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(en_i) && flt_q != $past(flt_q)) |-> flt_q == $past(s2_q));
  assert_edge_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o));
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tif_capture_front.sv
module tif_capture_front
  import tif_pkg::*;
#(
  parameter int NPIN     = 2,
  parameter int STABLE   = 3,
  parameter int DIV_FAST = 8,
  parameter int DIV_SLOW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            cfg_we_i,
  input  logic [1:0]      fsel_i,
  input  logic            cap_src_i,
  input  logic [NPIN-1:0] flt_en_i,
  input  logic            cnt_src_tick_i,
  input  logic [1:0]      cap_edge_i,
  input  logic [NPIN-1:0] pin_i,
  input  logic            evt_i,
  output logic [NPIN-1:0] lvl_o,
  output logic [NPIN-1:0] rise_o,
  output logic [NPIN-1:0] fall_o,
  output logic            cap_req_o
);
  fsel_e  fsel_q;
  logic   src_q;
  logic   stb;
  logic   pin_hit;
  logic   cap_q;
  cedge_e cedge;

  assign cedge = cedge_e'(cap_edge_i);

  // settings accept a write only while the timer runs
  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_q <= FSEL_DIV32;
      src_q  <= 1'b0;
    end else if (cfg_we_i && start_i) begin
      fsel_q <= fsel_e'(fsel_i);
      src_q  <= cap_src_i;
    end
  end

  tif_strobe_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_stb (
    .clk            (clk),
    .rst            (rst),
    .fsel_i         (fsel_q),
    .cnt_src_tick_i (cnt_src_tick_i),
    .stb_o          (stb)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    tif_pin_filter #(.STABLE(STABLE)) u_flt (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pin_i[p]),
      .en_i   (flt_en_i[p]),
      .stb_i  (stb),
      .lvl_o  (lvl_o[p]),
      .rise_o (rise_o[p]),
      .fall_o (fall_o[p])
    );
  end

  always_comb begin
    unique case (cedge)
      CEDGE_RISE: pin_hit = rise_o[0];
      CEDGE_FALL: pin_hit = fall_o[0];
      CEDGE_BOTH: pin_hit = rise_o[0] | fall_o[0];
      default:    pin_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cap_q <= 1'b0;
    else     cap_q <= src_q ? (evt_i && cedge == CEDGE_RISE) : pin_hit;
  end

  assign cap_req_o = cap_q;

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(start_i) |-> ($stable(fsel_q) && $stable(src_q)));
  assert_evt_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (cap_req_o && $past(src_q)) |-> ($past(evt_i) && $past(cap_edge_i) == 2'b00));
  assert_pin_path_R6: assert property (@(posedge clk) disable iff (rst)
    (cap_req_o && !$past(src_q)) |-> ($past(rise_o[0]) || $past(fall_o[0])));
endmodule

// File: tb/tb_tif_capture_front.sv
`timescale 1ns/1ps
module tb_tif_capture_front;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, cfg_we = 1'b0, cap_src = 1'b0, tick = 1'b0, evt = 1'b0;
  logic [1:0] fsel = 2'b00, cap_edge = 2'b00;
  logic [1:0] flt_en = 2'b00, pin = 2'b10;
  logic [1:0] lvl, rise, fall;
  logic       cap;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  tif_capture_front dut (
    .clk(clk), .rst(rst), .start_i(start), .cfg_we_i(cfg_we), .fsel_i(fsel),
    .cap_src_i(cap_src), .flt_en_i(flt_en), .cnt_src_tick_i(tick),
    .cap_edge_i(cap_edge), .pin_i(pin), .evt_i(evt),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall), .cap_req_o(cap)
  );

  // count-source tick: one clock in every four
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      tick = (k % 4 == 3);
      k++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] s, input logic src);
    @(negedge clk);
    fsel = s; cap_src = src; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // toggle pin[idx]; toggle back after hold clocks (0 = keep)
  // first: clock of first edge pulse (-1 none); npulse: pulses seen; capc: first cap clock
  task automatic probe(input int idx, input bit want_rise, input int hold, input int win,
                       output int first, output int npulse, output int capc);
    first = -1; npulse = 0; capc = -1;
    pin[idx] = ~pin[idx];
    for (int c = 1; c <= win; c++) begin
      @(negedge clk);
      if (c == hold) pin[idx] = ~pin[idx];
      if ((want_rise ? rise[idx] : fall[idx]) == 1'b1) begin
        npulse++;
        if (first < 0) first = c;
      end
      if (cap && capc < 0) capc = c;
    end
  endtask

  // {fsel[27:26], en[25], hold[24:17], expect[16], lmin[15:8], lmax[7:0]}
  localparam int NV = 11;
  localparam logic [27:0] VEC [NV] = '{
    {2'b10, 1'b0, 8'd20,  1'b1, 8'd3,  8'd3 },  // R2 bypass
    {2'b10, 1'b1, 8'd20,  1'b1, 8'd6,  8'd6 },  // R3 every-clock strobe
    {2'b10, 1'b1, 8'd2,   1'b0, 8'd0,  8'd0 },  // R3 2-clock glitch
    {2'b10, 1'b1, 8'd3,   1'b1, 8'd6,  8'd6 },  // R3 3-clock pulse
    {2'b01, 1'b1, 8'd60,  1'b1, 8'd20, 8'd27},  // R4 div 8
    {2'b01, 1'b1, 8'd8,   1'b0, 8'd0,  8'd0 },  // R4 div 8 glitch
    {2'b00, 1'b1, 8'd200, 1'b1, 8'd68, 8'd99},  // R4 div 32
    {2'b00, 1'b1, 8'd40,  1'b0, 8'd0,  8'd0 },  // R4 div 32 glitch
    {2'b11, 1'b1, 8'd40,  1'b1, 8'd12, 8'd15},  // R4 tick every 4
    {2'b11, 1'b1, 8'd7,   1'b0, 8'd0,  8'd0 },  // R4 tick glitch
    {2'b00, 1'b0, 8'd5,   1'b1, 8'd3,  8'd3 }   // R2 bypass ignores select
  };

  initial begin
    int first, np, capc;
    // watchdog
    fork
      begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none

    // R1 reset state, pin1 high and pin0 low during reset
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(1);
    chk(lvl == 2'b10, "R1 level", lvl, 2);
    chk(rise == 2'b00 && fall == 2'b00 && cap == 1'b0, "R1 pulses", {rise, fall, cap}, 0);
    idle(10);
    chk(rise == 2'b00 && fall == 2'b00, "R1 quiet", {rise, fall}, 0);

    // R1 default select is div 32: filtered edge in its window
    flt_en = 2'b11; start = 1'b1;
    probe(0, 1'b1, 0, 130, first, np, capc);
    chk(first >= 68 && first <= 99, "R1 default select", first, 68);
    pin[0] = 1'b0; idle(130);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [27:0] e;
      e = VEC[v];
      flt_en[0] = e[25];
      cfg(e[27:26], 1'b0);
      idle(140);
      probe(0, 1'b1, int'(e[24:17]), 130, first, np, capc);
      if (e[16]) begin
        chk(first >= int'(e[15:8]) && first <= int'(e[7:0]), "R3/R4 latency", first, int'(e[15:8]));
        chk(np == 1, "R5 one pulse", np, 1);
        chk(capc == first + 1, "R6 capture follows rise", capc, first + 1);
      end else begin
        chk(first == -1, "R3/R4 glitch rejected", first, -1);
        chk(capc == -1, "R6 no capture on glitch", capc, -1);
      end
      pin[0] = 1'b0; idle(140);
    end

    // R5 pin 1 falling edge, pin 0 untouched, every-clock strobe
    cfg(2'b10, 1'b0);
    flt_en = 2'b11; idle(10);
    probe(1, 1'b0, 0, 20, first, np, capc);
    chk(first == 6 && np == 1, "R5 pin1 fall", first, 6);
    chk(lvl == 2'b00 && rise == 2'b00, "R5 pin independence", {lvl, rise}, 0);
    chk(capc == -1, "R6 pin1 no capture", capc, -1);

    // R6 falling edge select on pin 0, bypassed
    flt_en = 2'b00; cap_edge = 2'b01; idle(5);
    probe(0, 1'b1, 0, 10, first, np, capc);
    chk(capc == -1, "R6 rise ignored for fall select", capc, -1);
    probe(0, 1'b0, 0, 10, first, np, capc);
    chk(first == 3 && capc == 4, "R6 fall capture", capc, 4);
    cap_edge = 2'b11;
    probe(0, 1'b1, 0, 10, first, np, capc);
    chk(first == 3 && capc == -1, "R6 none select", capc, -1);
    pin[0] = 1'b0; idle(10);

    // R7 event source
    cap_edge = 2'b00;
    cfg(2'b10, 1'b1);
    @(negedge clk); evt = 1'b1;
    @(negedge clk); evt = 1'b0;
    chk(cap == 1'b1, "R7 event capture", cap, 1);
    @(negedge clk);
    chk(cap == 1'b0, "R7 event one clock", cap, 0);
    cap_edge = 2'b01;
    @(negedge clk); evt = 1'b1;
    @(negedge clk); evt = 1'b0;
    chk(cap == 1'b0, "R7 event needs rising config", cap, 0);
    cap_edge = 2'b00;
    probe(0, 1'b1, 0, 10, first, np, capc);
    chk(capc == -1, "R7 pin ignored with event source", capc, -1);
    pin[0] = 1'b0; idle(10);

    // R8 writes while stopped are ignored
    start = 1'b0;
    cfg(2'b00, 1'b0);
    @(negedge clk); evt = 1'b1;
    @(negedge clk); evt = 1'b0;
    chk(cap == 1'b1, "R8 source kept", cap, 1);
    flt_en = 2'b11; idle(5);
    probe(1, 1'b1, 0, 20, first, np, capc);
    chk(first == 6, "R8 select kept", first, 6);
    start = 1'b1;
    cfg(2'b00, 1'b0);
    @(negedge clk); evt = 1'b1;
    @(negedge clk); evt = 1'b0;
    chk(cap == 1'b0, "R8 write while running", cap, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule